// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

An 8-bit down-counter clocked through a 7-bit down-counting prescaler whose division ratio is chosen from eight power-of-two taps. Software drives it through three byte-wide registers on a small register bus: a control/status byte, the counter byte and the prescaler byte. When the counter decrements to zero it raises a zero flag, stops at zero and, if enabled, requests an interrupt. The zero flag can also be forced by software.

The block owns one timer pin. In output mode the pin value comes from a latch that passes the data-out control bit while the zero flag is high and holds its last value while the flag is low. In input mode the output driver is off and the pin level, passed through a two-flop synchroniser, can be read through the control byte.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the control byte reads 0x00, the counter reads 0xFF, the prescaler reads 0x7F, irq_o is 0 and pin_oe_o is 0.
- R2: Address 0 is the control byte with bit 7 zero flag, bit 6 interrupt enable, bit 5 output mode, bit 4 data-out, bit 3 run, bits 2:0 tap code; address 1 is the counter and address 2 the prescaler. rdata_o is 0x00 when rd_en_i is low or the address is 3.
- R3: While run is 0 the prescaler stays at 0x7F and the counter changes only through a counter write.
- R4: With run at 1 and tap code n, the counter decrements on the 2^n-th clock edge after the edge that set run and then once every 2^n edges.
- R5: A decrement from 1 to 0 sets the zero flag; the counter then stays at 0x00 until it is written.
- R6: Writing 0x00 to the counter, or writing the control byte with bit 7 set, sets the zero flag; writing the control byte with bit 7 clear clears it.
- R7: A counter write in the same cycle as a decrement to zero loads the written value and leaves the zero flag clear.
- R8: A decrement to zero in the same cycle as a control write with bit 7 clear leaves the zero flag set.
- R9: irq_o is high exactly when both the zero flag and the interrupt enable are 1.
- R10: pin_oe_o equals the output mode bit; pin_out_o equals the data-out bit while the zero flag is 1 and holds the last such value while it is 0.
- R11: With output mode 0, control bit 4 reads the pin input as sampled by two flops, valid two edges after the pin changes.
- R12: The prescaler reads back its live 7-bit count with bit 7 as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe, acts at the clock edge |
| rd_en_i | input | 1 | Read strobe, combinational read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request |
| pin_oe_o | output | 1 | Pin output enable |
| pin_out_o | output | 1 | Pin output value |
| pin_in_i | input | 1 | Pin input level |

## Verification
Two pairs of events can coincide: a counter write on the edge where the counter would reach zero, and a flag-clearing control write on that same edge. Both are provoked with tap code 0 so the decrement edge is known exactly: the counter is loaded with 3 or 1, run is set, and the competing write is issued on the edge where the count goes from 1 to 0. The bench then judges the counter value and the zero flag read back through the control byte against the precedence rules.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int CNT_W = 8;
  localparam int PSC_W = 7;
  localparam int TAP_W = 3;
  localparam int BUS_W = 8;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_CNT  = 2'd1,
    ADDR_PSC  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             zero;
    logic             irq_en;
    logic             out_mode;
    logic             dout;
    logic             run;
    logic [TAP_W-1:0] tap;
  } ctrl_t;
endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PSC_W = 7,
  parameter int TAP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [PSC_W-1:0] wdata_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic [PSC_W-1:0] value_o,
  output logic             tick_o
);
  localparam logic [PSC_W-1:0] ALL_ONES = {PSC_W{1'b1}};

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] tap_mask;

  // low tap_i bits all zero marks the end of a 2^tap period
  assign tap_mask = ~(ALL_ONES << tap_i);
  assign tick_o   = run_i && ((psc_q & tap_mask) == '0);
  assign value_o  = psc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     psc_q <= ALL_ONES;
    else if (!run_i) psc_q <= ALL_ONES;
    else if (wr_i)   psc_q <= wdata_i;
    else             psc_q <= psc_q - 1'b1;
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] value_o,
  output logic             hit_zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign value_o    = cnt_q;
  assign hit_zero_o = tick_i && !wr_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '1;
    else if (wr_i)                  cnt_q <= wdata_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/timer_pin.sv
module timer_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic zero_i,
  input  logic out_mode_i,
  input  logic dout_i,
  input  logic pin_in_i,
  output logic pin_oe_o,
  output logic pin_out_o,
  output logic pin_sync_o
);
  logic held_q;
  logic sync_q1, sync_q2;

  // held_q is the closed state of the latch; open while zero_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= 1'b0;
    else if (zero_i) held_q <= dout_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= pin_in_i;
      sync_q2 <= sync_q1;
    end
  end

  assign pin_oe_o   = out_mode_i;
  assign pin_out_o  = zero_i ? dout_i : held_q;
  assign pin_sync_o = sync_q2;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             irq_o,
  output logic             pin_oe_o,
  output logic             pin_out_o,
  input  logic             pin_in_i
);
  ctrl_t            ctrl_q;
  logic             ctrl_wr, cnt_wr, psc_wr;
  logic             tick, hit_zero, zero_set, zero_clr;
  logic             pin_sync;
  logic [CNT_W-1:0] cnt_val;
  logic [PSC_W-1:0] psc_val;
  ctrl_t            ctrl_wd;

  assign ctrl_wd = ctrl_t'(wdata_i);
  assign ctrl_wr = wr_en_i && (reg_addr_e'(addr_i) == ADDR_CTRL);
  assign cnt_wr  = wr_en_i && (reg_addr_e'(addr_i) == ADDR_CNT);
  assign psc_wr  = wr_en_i && (reg_addr_e'(addr_i) == ADDR_PSC);

  timer_prescaler #(.PSC_W(PSC_W), .TAP_W(TAP_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (ctrl_q.run),
    .wr_i    (psc_wr),
    .wdata_i (wdata_i[PSC_W-1:0]),
    .tap_i   (ctrl_q.tap),
    .value_o (psc_val),
    .tick_o  (tick)
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .wr_i       (cnt_wr),
    .wdata_i    (wdata_i[CNT_W-1:0]),
    .value_o    (cnt_val),
    .hit_zero_o (hit_zero)
  );

  // any set source beats a clearing control write
  assign zero_set = hit_zero || (cnt_wr && wdata_i[CNT_W-1:0] == '0) || (ctrl_wr && ctrl_wd.zero);
  assign zero_clr = ctrl_wr && !ctrl_wd.zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (zero_set)      ctrl_q.zero <= 1'b1;
      else if (zero_clr) ctrl_q.zero <= 1'b0;
      if (ctrl_wr) begin
        ctrl_q.irq_en   <= ctrl_wd.irq_en;
        ctrl_q.out_mode <= ctrl_wd.out_mode;
        ctrl_q.dout     <= ctrl_wd.dout;
        ctrl_q.run      <= ctrl_wd.run;
        ctrl_q.tap      <= ctrl_wd.tap;
      end
    end
  end

  timer_pin u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_i     (ctrl_q.zero),
    .out_mode_i (ctrl_q.out_mode),
    .dout_i     (ctrl_q.dout),
    .pin_in_i   (pin_in_i),
    .pin_oe_o   (pin_oe_o),
    .pin_out_o  (pin_out_o),
    .pin_sync_o (pin_sync)
  );

  assign irq_o = ctrl_q.irq_en && ctrl_q.zero;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (reg_addr_e'(addr_i))
        ADDR_CTRL: rdata_o = {ctrl_q.zero, ctrl_q.irq_en, ctrl_q.out_mode,
                              ctrl_q.out_mode ? ctrl_q.dout : pin_sync,
                              ctrl_q.run, ctrl_q.tap};
        ADDR_CNT:  rdata_o = BUS_W'(cnt_val);
        ADDR_PSC:  rdata_o = BUS_W'(psc_val);
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             tick,
  input logic             cnt_wr,
  input logic [7:0]       wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [PSC_W-1:0] psc,
  input logic             zero,
  input logic             irq_o,
  input logic             pin_out_o
);
  assert_psc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> psc == {PSC_W{1'b1}});

  assert_cnt_freeze_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_wr) |=> $stable(cnt));

  assert_decrement_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_wr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  assert_zero_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_wr && cnt == CNT_W'(1)) |=> zero);

  assert_stop_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !cnt_wr) |=> cnt == '0);

  assert_write_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt == $past(wdata[CNT_W-1:0]));

  assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> zero);

  assert_pin_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zero ##1 !zero) |-> $stable(pin_out_o));
endmodule

bind prescaled_timer timer_checker #(.CNT_W(timer_pkg::CNT_W), .PSC_W(timer_pkg::PSC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run       (ctrl_q.run),
  .tick      (tick),
  .cnt_wr    (cnt_wr),
  .wdata     (wdata_i),
  .cnt       (cnt_val),
  .psc       (psc_val),
  .zero      (ctrl_q.zero),
  .irq_o     (irq_o),
  .pin_out_o (pin_out_o)
);

// File: tb/sim_prescaled_timer.sv
`timescale 1ns/1ps
module sim_prescaled_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, pin_oe_o, pin_out_o;
  logic       pin_in_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk_i = ~clk_i;

  prescaled_timer u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd1, d); check("R1 cnt", d, 8'hFF);
    rd(2'd2, d); check("R1 psc", d, 8'h7F);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    check("R1 oe", {7'd0, pin_oe_o}, 8'h00);
    rd(2'd3, d); check("R2 unmapped", d, 8'h00);
    addr_i = 2'd1; #1 check("R2 no rd_en", rdata_o, 8'h00);
  endtask

  task automatic t_stopped;
    logic [7:0] d;
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h03);          // run=0, tap 3
    idle(10);
    rd(2'd1, d); check("R3 cnt held", d, 8'h40);
    rd(2'd2, d); check("R3 psc held", d, 8'h7F);
    rd(2'd0, d); check("R2 ctrl readback", d, 8'h03);
  endtask

  task automatic t_tap0;
    logic [7:0] d;
    wr(2'd1, 8'h05);
    wr(2'd0, 8'h08);          // run, tap 0
    idle(4);
    rd(2'd1, d); check("R4 tap0 cnt", d, 8'h01);
    rd(2'd0, d); check("R5 flag low before zero", d & 8'h80, 8'h00);
    idle(1);
    rd(2'd1, d); check("R5 cnt zero", d, 8'h00);
    rd(2'd0, d); check("R5 flag set", d & 8'h80, 8'h80);
    idle(5);
    rd(2'd1, d); check("R5 stop at zero", d, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R6 flag clear", d, 8'h00);
  endtask

  task automatic t_tap3;
    logic [7:0] d;
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h0B);          // run, tap 3
    idle(7);
    rd(2'd1, d); check("R4 tap3 before first", d, 8'h03);
    idle(1);
    rd(2'd1, d); check("R4 tap3 first", d, 8'h02);
    rd(2'd2, d); check("R12 psc live", d, 8'h77);
    idle(15);
    rd(2'd1, d); check("R4 tap3 period", d, 8'h01);
    idle(1);
    rd(2'd1, d); check("R4 tap3 zero", d, 8'h00);
    rd(2'd0, d); check("R5 tap3 flag", d & 8'h80, 8'h80);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'hFF);          // stopped: write ignored, bit7 reads 0
    rd(2'd2, d); check("R12 psc bit7", d, 8'h7F);
  endtask

  task automatic t_write_wins;
    logic [7:0] d;
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h08);
    idle(2);                  // counter now 1
    wr(2'd1, 8'h20);          // same edge as decrement to zero
    rd(2'd1, d); check("R7 write value", d, 8'h20);
    rd(2'd0, d); check("R7 flag clear", d & 8'h80, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_set_beats_clear;
    logic [7:0] d;
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h08);          // clearing write on the zero edge
    rd(2'd0, d); check("R8 flag kept", d & 8'h80, 8'h80);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_soft_set_irq;
    logic [7:0] d;
    wr(2'd0, 8'h80);
    rd(2'd0, d); check("R6 ctrl force", d, 8'h80);
    check("R9 irq off", {7'd0, irq_o}, 8'h00);
    wr(2'd0, 8'hC0);
    check("R9 irq on", {7'd0, irq_o}, 8'h01);
    wr(2'd0, 8'h40);
    check("R9 irq cleared", {7'd0, irq_o}, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd0, d); check("R6 cnt write zero", d & 8'h80, 8'h80);
    check("R9 irq from cnt write", {7'd0, irq_o}, 8'h01);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_pin;
    logic [7:0] d;
    wr(2'd0, 8'hB0);          // zero, out mode, dout=1
    check("R10 oe", {7'd0, pin_oe_o}, 8'h01);
    check("R10 transparent 1", {7'd0, pin_out_o}, 8'h01);
    wr(2'd0, 8'h20);          // clear flag, dout=0
    check("R10 latched", {7'd0, pin_out_o}, 8'h01);
    idle(3);
    check("R10 still latched", {7'd0, pin_out_o}, 8'h01);
    wr(2'd0, 8'hA0);          // zero again, dout=0
    check("R10 transparent 0", {7'd0, pin_out_o}, 8'h00);
    wr(2'd0, 8'h00);
    check("R10 oe off", {7'd0, pin_oe_o}, 8'h00);
  endtask

  task automatic t_input;
    logic [7:0] d;
    pin_in_i = 1'b1;
    idle(1);
    rd(2'd0, d); check("R11 not yet", d & 8'h10, 8'h00);
    idle(1);
    rd(2'd0, d); check("R11 synced", d & 8'h10, 8'h10);
    pin_in_i = 1'b0;
    idle(2);
    rd(2'd0, d); check("R11 low", d & 8'h10, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    t_reset;
    t_stopped;
    t_tap0;
    t_tap3;
    t_write_wins;
    t_set_beats_clear;
    t_soft_set_irq;
    t_pin;
    t_input;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule